// File: doc/BRIEF.md
# Interlaced Video Sync and Field Generator

This block builds the output timing of an interlaced video decoder from a pixel clock. It runs a pixel counter and a line counter over a 525-line or 625-line frame. It drives an active-low horizontal sync once per line and an active-low vertical sync once per field. It also drives a field-identity flag that is high for odd fields.

A receiver can tell the field type from the vertical sync alone, because the block moves the rising (trailing) edge of vertical sync according to the field being entered:
- **Odd field:** the edge lands a fixed offset after the rising edge of horizontal sync.
- **Even field:** the edge lands the same offset after the falling edge of horizontal sync.

The field flag changes a fixed number of clocks before each falling edge of vertical sync. When the upstream decoder marks its field parity as valid, the flag copies that parity. Otherwise it alternates every field.

The standard select is sampled only where one frame ends and the next begins, so every frame and field keeps a consistent length. All inputs are plain control pins; the block has no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `ilace_sync_gen`

## Requirements
- R1: `hsync_n` is low for `HS_WIDTH` clocks, and its falling edges are exactly `LINE_PIX` clocks apart.
- R2: Every falling edge of `vsync_n` falls in the same clock as a falling edge of `hsync_n`.
- R3: `field_odd` changes exactly `FIELD_LEAD` clocks before a falling edge of `vsync_n`, and does not change at any other time.
- R4: When a field is entered with `field_odd` = 1, `vsync_n` rises `TAIL_OFS` clocks after a rising edge of `hsync_n`. Its low time is `VS_LINES*LINE_PIX + HS_WIDTH + TAIL_OFS` clocks.
- R5: When a field is entered with `field_odd` = 0, `vsync_n` rises `TAIL_OFS` clocks after a falling edge of `hsync_n`. Its low time is `VS_LINES*LINE_PIX + TAIL_OFS` clocks.
- R6: With `ext_valid` = 0, `field_odd` inverts at every field start.
- R7: With `ext_valid` = 1, the new `field_odd` value equals `ext_field` (1 = odd) as sampled at the field change point. It may therefore stay unchanged across a field start.
- R8: Vertical sync falls at line 1 and at a mid-frame line. That line is 264 when `std_sel` = 0 (525 lines) and 314 when `std_sel` = 1 (625 lines). Successive falls are therefore 263/262 lines apart in 525-line mode and 313/312 lines apart in 625-line mode.
- R9: A change of `std_sel` takes effect only at the next wrap from the last line of the frame to line 1.
- R10: While `rst` is high, all three outputs are high. At the first clock edge after release, both syncs fall and `field_odd` stays 1: line 1 of an odd field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| std_sel | input | 1 | Line standard: 0 = 525 lines, 1 = 625 lines |
| ext_valid | input | 1 | Upstream field parity is trustworthy |
| ext_field | input | 1 | Upstream field parity, 1 = odd |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| field_odd | output | 1 | Field identity, 1 = odd field |

## Verification
The hardest situation to reach is a field whose `field_odd` value differs from what free-running alternation would give. Only that case shows that the trailing-edge placement follows the flag rather than the field's position in the frame. The bench gets there by raising `ext_valid` right after a field has started and then presenting an `ext_field` parity. It does this twice:
- once so that the flag stays odd across a mid-frame field start, where a change to even would be expected;
- once so that the flag turns even at line 1, where a change to odd would be expected.

In both cases it then measures the vertical sync low time and its offset from the preceding horizontal edge. Separately, `std_sel` is changed early in a frame, and the bench confirms that the two following field intervals still have 525-line length before 625-line lengths appear.

// File: rtl/isg_pkg.sv
package isg_pkg;

  typedef enum logic {
    STD_525 = 1'b0,
    STD_625 = 1'b1
  } isg_std_e;

  localparam int unsigned LINE_W = 10;

  function automatic int unsigned frame_lines(isg_std_e s);
    return (s == STD_625) ? 625 : 525;
  endfunction

  // first line of the vertical sync window that opens the even-position field
  function automatic int unsigned mid_start(isg_std_e s);
    return frame_lines(s) / 2 + 2;
  endfunction

endpackage

// File: rtl/isg_timebase.sv
module isg_timebase
  import isg_pkg::*;
#(
  parameter int unsigned LINE_PIX = 858,
  parameter int unsigned PIX_W    = $clog2(LINE_PIX)
) (
  input  logic              clk,
  input  logic              rst,
  input  isg_std_e          std_sel,
  output logic [PIX_W-1:0]  pix,
  output logic [LINE_W-1:0] line,
  output isg_std_e          std_q
);

  localparam logic [PIX_W-1:0] LAST_PIX = PIX_W'(LINE_PIX - 1);

  logic [LINE_W-1:0] last_line;
  logic              eol;
  logic              eof;

  always_comb begin
    last_line = LINE_W'(frame_lines(std_q));
    eol       = (pix == LAST_PIX);
    eof       = eol && (line == last_line);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix   <= '0;
      line  <= LINE_W'(1);
      std_q <= std_sel;
    end else if (eol) begin
      pix <= '0;
      if (eof) begin
        line  <= LINE_W'(1);
        std_q <= std_sel;
      end else begin
        line <= line + LINE_W'(1);
      end
    end else begin
      pix <= pix + PIX_W'(1);
    end
  end

  // R9
  std_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !eof |=> $stable(std_q));

endmodule

// File: rtl/isg_field_ctl.sv
module isg_field_ctl
  import isg_pkg::*;
#(
  parameter int unsigned LINE_PIX   = 858,
  parameter int unsigned PIX_W      = $clog2(LINE_PIX),
  parameter int unsigned HS_WIDTH   = 64,
  parameter int unsigned VS_LINES   = 3,
  parameter int unsigned FIELD_LEAD = 5,
  parameter int unsigned TAIL_OFS   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIX_W-1:0]  pix,
  input  logic [LINE_W-1:0] line,
  input  isg_std_e          std_q,
  input  logic              ext_valid,
  input  logic              ext_field,
  output logic              field_q,
  output logic              vs_on
);

  localparam logic [PIX_W-1:0]  LEAD_PIX  = PIX_W'(LINE_PIX - FIELD_LEAD);
  localparam logic [PIX_W-1:0]  ODD_TAIL  = PIX_W'(HS_WIDTH + TAIL_OFS);
  localparam logic [PIX_W-1:0]  EVEN_TAIL = PIX_W'(TAIL_OFS);
  localparam logic [LINE_W-1:0] VS_L      = LINE_W'(VS_LINES);

  logic [LINE_W-1:0] last_line;
  logic [LINE_W-1:0] mid_line;
  logic              fld_pt;
  logic              in_top;
  logic              in_mid;
  logic              tail_line;
  logic [PIX_W-1:0]  tail_pix;

  always_comb begin
    last_line = LINE_W'(frame_lines(std_q));
    mid_line  = LINE_W'(mid_start(std_q));
    fld_pt    = (pix == LEAD_PIX) &&
                ((line == last_line) || (line == mid_line - LINE_W'(1)));
    in_top    = (line <= VS_L);
    in_mid    = (line >= mid_line) && (line < mid_line + VS_L);
    tail_line = (line == VS_L + LINE_W'(1)) || (line == mid_line + VS_L);
    tail_pix  = field_q ? ODD_TAIL : EVEN_TAIL;
    vs_on     = in_top || in_mid || (tail_line && (pix < tail_pix));
  end

  always_ff @(posedge clk) begin
    if (rst) field_q <= 1'b1;
    else if (fld_pt) field_q <= ext_valid ? ext_field : ~field_q;
  end

  // R3
  field_when_chk: assert property (@(posedge clk) disable iff (rst)
    (field_q != $past(field_q)) |-> $past(fld_pt));

  // R6
  field_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (fld_pt && !ext_valid) |=> (field_q != $past(field_q)));

endmodule

// File: rtl/isg_sync_out.sv
module isg_sync_out #(
  parameter int unsigned LINE_PIX = 858,
  parameter int unsigned PIX_W    = $clog2(LINE_PIX),
  parameter int unsigned HS_WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pix,
  input  logic             vs_on,
  output logic             hsync_n,
  output logic             vsync_n
);

  localparam logic [PIX_W-1:0] HS_END = PIX_W'(HS_WIDTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
    end else begin
      hsync_n <= !(pix < HS_END);
      vsync_n <= !vs_on;
    end
  end

  // R2
  vs_on_hs_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(vsync_n) |-> $fell(hsync_n));

endmodule

// File: rtl/ilace_sync_gen.sv
module ilace_sync_gen
  import isg_pkg::*;
#(
  parameter int unsigned LINE_PIX   = 858,
  parameter int unsigned HS_WIDTH   = 64,
  parameter int unsigned VS_LINES   = 3,
  parameter int unsigned FIELD_LEAD = 5,
  parameter int unsigned TAIL_OFS   = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic std_sel,
  input  logic ext_valid,
  input  logic ext_field,
  output logic hsync_n,
  output logic vsync_n,
  output logic field_odd
);

  localparam int unsigned PIX_W = $clog2(LINE_PIX);

  logic [PIX_W-1:0]  pix;
  logic [LINE_W-1:0] line;
  isg_std_e          std_q;
  logic              vs_on;

  isg_timebase #(.LINE_PIX(LINE_PIX), .PIX_W(PIX_W)) u_tb (
    .clk(clk), .rst(rst), .std_sel(isg_std_e'(std_sel)),
    .pix(pix), .line(line), .std_q(std_q)
  );

  isg_field_ctl #(
    .LINE_PIX(LINE_PIX), .PIX_W(PIX_W), .HS_WIDTH(HS_WIDTH),
    .VS_LINES(VS_LINES), .FIELD_LEAD(FIELD_LEAD), .TAIL_OFS(TAIL_OFS)
  ) u_fld (
    .clk(clk), .rst(rst), .pix(pix), .line(line), .std_q(std_q),
    .ext_valid(ext_valid), .ext_field(ext_field),
    .field_q(field_odd), .vs_on(vs_on)
  );

  isg_sync_out #(.LINE_PIX(LINE_PIX), .PIX_W(PIX_W), .HS_WIDTH(HS_WIDTH)) u_out (
    .clk(clk), .rst(rst), .pix(pix), .vs_on(vs_on),
    .hsync_n(hsync_n), .vsync_n(vsync_n)
  );

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (hsync_n && vsync_n && field_odd));

endmodule

// File: tb/ilace_sync_gen_tb.sv
module ilace_sync_gen_tb;

  localparam int LP   = 32;
  localparam int HSW  = 4;
  localparam int VSL  = 3;
  localparam int LEAD = 5;
  localparam int OFS  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic std_sel = 1'b0;
  logic ext_valid = 1'b0;
  logic ext_field = 1'b0;
  logic hsync_n, vsync_n, field_odd;

  always #4 clk = ~clk;

  ilace_sync_gen #(.LINE_PIX(LP), .HS_WIDTH(HSW), .VS_LINES(VSL),
                   .FIELD_LEAD(LEAD), .TAIL_OFS(OFS)) u_dut (
    .clk(clk), .rst(rst), .std_sel(std_sel), .ext_valid(ext_valid),
    .ext_field(ext_field), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .field_odd(field_odd)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int t_hsf = 0, t_hsr = 0, t_vsf = 0, t_vsr = 0, t_fc = 0;
  int n_hsf = 0, n_hsr = 0, n_vsf = 0, n_vsr = 0, n_fc = 0;
  bit hs_at_vsf = 1'b0;
  logic ph = 1'b1, pv = 1'b1, pf = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (ph && !hsync_n) begin t_hsf = cyc; n_hsf++; end
      if (!ph && hsync_n) begin t_hsr = cyc; n_hsr++; end
      if (pv && !vsync_n) begin t_vsf = cyc; hs_at_vsf = (t_hsf == cyc); n_vsf++; end
      if (!pv && vsync_n) begin t_vsr = cyc; n_vsr++; end
      if (pf !== field_odd) begin t_fc = cyc; n_fc++; end
    end
    ph = hsync_n; pv = vsync_n; pf = field_odd;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(hsync_n == 1'b1, "R10", "hsync_n in reset", hsync_n, 1);
    chk(vsync_n == 1'b1, "R10", "vsync_n in reset", vsync_n, 1);
    chk(field_odd == 1'b1, "R10", "field in reset", field_odd, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(hsync_n == 1'b0, "R10", "hsync_n after release", hsync_n, 0);
    chk(vsync_n == 1'b0, "R10", "vsync_n after release", vsync_n, 0);
    chk(field_odd == 1'b1, "R10", "field after release", field_odd, 1);
  endtask

  task automatic t_first_field();
    int old, a;
    old = n_hsr; wait (n_hsr != old);
    chk(t_hsr - t_hsf == HSW, "R1", "hsync low width", t_hsr - t_hsf, HSW);
    old = n_hsf; wait (n_hsf != old); a = t_hsf;
    old = n_hsf; wait (n_hsf != old);
    chk(t_hsf - a == LP, "R1", "hsync period", t_hsf - a, LP);
    old = n_vsr; wait (n_vsr != old);
    chk(t_vsr - t_vsf == VSL*LP + HSW + OFS, "R4", "first odd vsync low time",
        t_vsr - t_vsf, VSL*LP + HSW + OFS);
    chk(t_vsr - t_hsr >= OFS-1 && t_vsr - t_hsr <= OFS+1, "R4",
        "first odd tail after hsync rise", t_vsr - t_hsr, OFS);
  endtask

  task automatic field_cycle(input bit exp_f, input int exp_lines,
                             input int exp_chg, input string freq);
    int prev, fc0, old, len_exp, ofs;
    prev = t_vsf; fc0 = n_fc;
    old = n_vsf; wait (n_vsf != old);
    chk(field_odd == exp_f, freq, "field value at vsync fall", field_odd, exp_f);
    chk(t_vsf - prev == exp_lines*LP, "R8", "vsync fall interval",
        t_vsf - prev, exp_lines*LP);
    chk(hs_at_vsf, "R2", "hsync falls with vsync", hs_at_vsf, 1);
    chk(n_fc - fc0 == exp_chg, "R3", "field changes in field", n_fc - fc0, exp_chg);
    if (exp_chg == 1)
      chk(t_vsf - t_fc >= LEAD-1 && t_vsf - t_fc <= LEAD+1, "R3",
          "field lead before vsync", t_vsf - t_fc, LEAD);
    old = n_vsr; wait (n_vsr != old);
    if (exp_f) begin
      len_exp = VSL*LP + HSW + OFS;
      ofs = t_vsr - t_hsr;
      chk(t_vsr - t_vsf == len_exp, "R4", "odd vsync low time", t_vsr - t_vsf, len_exp);
      chk(ofs >= OFS-1 && ofs <= OFS+1, "R4", "odd tail after hsync rise", ofs, OFS);
    end else begin
      len_exp = VSL*LP + OFS;
      ofs = t_vsr - t_hsf;
      chk(t_vsr - t_vsf == len_exp, "R5", "even vsync low time", t_vsr - t_vsf, len_exp);
      chk(ofs >= OFS-1 && ofs <= OFS+1, "R5", "even tail after hsync fall", ofs, OFS);
    end
  endtask

  task automatic t_free_run();
    field_cycle(1'b0, 263, 1, "R6");
    field_cycle(1'b1, 262, 1, "R6");
  endtask

  task automatic t_external();
    ext_valid = 1'b1; ext_field = 1'b1;
    field_cycle(1'b1, 263, 0, "R7");
    ext_field = 1'b0;
    field_cycle(1'b0, 262, 1, "R7");
    ext_valid = 1'b0;
  endtask

  task automatic t_std_switch();
    std_sel = 1'b1;  // R9: mid-frame change must wait for the frame wrap
    field_cycle(1'b1, 263, 1, "R9");
    field_cycle(1'b0, 262, 1, "R9");
    field_cycle(1'b1, 313, 1, "R8");
    field_cycle(1'b0, 312, 1, "R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_first_field();
    t_free_run();
    t_external();
    t_std_switch();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule